// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between the load/store units of an out-of-order core and a single data-cache write port. Stores are allocated into it in program order, each carrying an age tag. The block returns the slot that the store occupies. The store's address and its data arrive later and independently, addressed by that slot. An in-order commit pulse marks the oldest uncommitted store as committed. Committed stores leave from the head, one per accepted cache write. A flush drops every uncommitted store that is younger than a given tag.

Each load presents its address and age tag and is resolved in the same cycle. Only stores older than the load take part. The load stalls if any of them still has an unknown address. It also stalls if the youngest older store with the same address has no data yet. If that youngest older match has its data, the load takes the data from the buffer. If no older store matches, the load goes to the cache ahead of the stores.

The store-allocate and cache-write interfaces are valid/ready. An allocation is taken on a cycle where both are high. The cache write is taken when `cw_valid` and `cw_ready` are both high, and its payload holds while `cw_ready` is low. The load interface uses `ld_ready` as its stall indication, and a result pulse is produced only while `ld_valid` is high. Commit, flush and the address/data updates are plain strobes.

Top module: `store_queue_fwd`

## Requirements
- R1: `st_alloc_ready` is low when 8 stores are held or when `flush_valid` is high. An accepted store takes the slot shown on `st_alloc_slot`. That slot is (head slot + occupancy) mod 8, so slots are handed out in rising order and wrap around.
- R2: `cw_valid` is high only while the oldest held store is committed. Stores leave through the cache port strictly oldest first, one per cycle with `cw_valid` and `cw_ready` both high. Each `st_commit` pulse commits the oldest uncommitted store.
- R3: While `cw_valid` is high and `cw_ready` is low, the store stays in the buffer and `cw_addr`/`cw_data` keep their values.
- R4: A store is older than a load when (load tag − store tag) mod 64 is nonzero and below 32. If any held store older than the load has an unknown address, `ld_ready` is low and neither `ld_fwd_valid` nor `ld_to_cache` is raised.
- R5: When every older store has a known address and none equals `ld_addr`, `ld_ready` is high and a valid load raises `ld_to_cache`. A younger store with an equal address has no effect on this outcome.
- R6: When one or more older stores match, the youngest of them supplies `ld_fwd_data`, with `ld_fwd_valid` high and `ld_to_cache` low.
- R7: If that youngest older match has no data yet, `ld_ready` is low, even when an older match has data.
- R8: The address compare covers all 32 bits. Addresses that differ only in bit 31 do not match.
- R9: A flush with tag F removes every uncommitted store whose tag is younger than F. Committed stores and stores not younger than F stay. The next allocation then takes the slot after the last kept store.
- R10: After reset the buffer is empty: `cw_valid` is low, `st_alloc_ready` is high, `st_alloc_slot` is 0, and any load goes to the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_alloc_valid | input | 1 | Store allocation request |
| st_alloc_ready | output | 1 | Buffer can take a store |
| st_alloc_age | input | 6 | Age tag of the allocated store |
| st_alloc_slot | output | 3 | Slot given to the allocated store |
| st_addr_valid | input | 1 | Address update strobe |
| st_addr_slot | input | 3 | Slot receiving the address |
| st_addr | input | 32 | Store effective address |
| st_data_valid | input | 1 | Data update strobe |
| st_data_slot | input | 3 | Slot receiving the data |
| st_data | input | 32 | Store data |
| st_commit | input | 1 | Commit the oldest uncommitted store |
| flush_valid | input | 1 | Flush request |
| flush_age | input | 6 | Uncommitted stores younger than this are dropped |
| ld_valid | input | 1 | Load present |
| ld_addr | input | 32 | Load effective address |
| ld_age | input | 6 | Load age tag |
| ld_ready | output | 1 | Load can be resolved this cycle (low = stall) |
| ld_fwd_valid | output | 1 | Load served from the buffer |
| ld_fwd_data | output | 32 | Forwarded data |
| ld_to_cache | output | 1 | Load may read the cache |
| cw_valid | output | 1 | Cache write request |
| cw_ready | input | 1 | Cache accepts the write |
| cw_addr | output | 32 | Cache write address |
| cw_data | output | 32 | Cache write data |

## Verification
Every port is compared on every cycle against a reference model, so internal faults show up within a cycle or two. A slipped head or occupancy count shows at once on `st_alloc_slot` and on the next cache write address. A lost commit or a wrong flush count makes `cw_valid` or the allocation slot diverge as soon as the affected entry reaches the head or the tail. A bad age or priority decision appears on the first load whose older set includes the faulty entry, as a wrong stall, a wrong forward source or a wrong cache path.

// File: rtl/sqf_pkg.sv
package sqf_pkg;

  typedef enum logic [1:0] {
    LD_BYPASS = 2'd0,
    LD_FWD    = 2'd1,
    LD_STALL  = 2'd2
  } ld_verdict_e;

endpackage

// File: rtl/sqf_age_cmp.sv
module sqf_age_cmp #(
  parameter int DEPTH = 8,
  parameter int AGE_W = 6
) (
  input  logic [DEPTH-1:0][AGE_W-1:0] l_age,
  input  logic [AGE_W-1:0]            ld_age,
  input  logic [AGE_W-1:0]            fl_age,
  output logic [DEPTH-1:0]            older_ld,
  output logic [DEPTH-1:0]            younger_fl
);

  // Tags live in a window smaller than half the tag space; the sign of the
  // modular difference gives program order.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [AGE_W-1:0] d_ld;
    logic [AGE_W-1:0] d_fl;
    assign d_ld = ld_age - l_age[g];
    assign d_fl = l_age[g] - fl_age;
    assign older_ld[g]   = (d_ld != '0) && !d_ld[AGE_W-1];
    assign younger_fl[g] = (d_fl != '0) && !d_fl[AGE_W-1];
  end

endmodule

// File: rtl/sqf_ld_resolve.sv
module sqf_ld_resolve
  import sqf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic [DEPTH-1:0]          live,
  input  logic [DEPTH-1:0]          older,
  input  logic [DEPTH-1:0]          a_known,
  input  logic [DEPTH-1:0]          d_known,
  input  logic [DEPTH-1:0][AW-1:0]  l_addr,
  input  logic [DEPTH-1:0][DW-1:0]  l_data,
  input  logic [AW-1:0]             ld_addr,
  output ld_verdict_e               verdict,
  output logic [DW-1:0]             fwd_data
);

  localparam int IDX_W = $clog2(DEPTH);

  logic             unknown_older;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  // Logical index 0 is the oldest store; scanning upward lets the youngest
  // older match overwrite earlier ones.
  always_comb begin
    unknown_older = 1'b0;
    hit           = 1'b0;
    hit_idx       = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live[i] && older[i]) begin
        if (!a_known[i]) begin
          unknown_older = 1'b1;
        end else if (l_addr[i] == ld_addr) begin
          hit     = 1'b1;
          hit_idx = IDX_W'(i);
        end
      end
    end
  end

  always_comb begin
    if (unknown_older || (hit && !d_known[hit_idx])) begin
      verdict = LD_STALL;
    end else if (hit) begin
      verdict = LD_FWD;
    end else begin
      verdict = LD_BYPASS;
    end
    fwd_data = l_data[hit_idx];
  end

endmodule

// File: rtl/sqf_ptr_ctrl.sv
module sqf_ptr_ctrl #(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_fire,
  input  logic                         drain_fire,
  input  logic                         commit_req,
  input  logic                         flush_req,
  input  logic [DEPTH-1:0]             younger,
  output logic [$clog2(DEPTH)-1:0]     head,
  output logic [$clog2(DEPTH)-1:0]     tail,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic [$clog2(DEPTH+1)-1:0]   ccount
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cc_c;
  logic [CNT_W-1:0] kept_n;
  logic [CNT_W-1:0] cnt_mid;

  // Commit is applied before the flush, so a store committed in the flush
  // cycle is kept. Ages rise from head to tail, so kept stores form a prefix.
  always_comb begin
    cc_c   = ccount + CNT_W'(commit_req && (ccount < count));
    kept_n = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) < count) && ((CNT_W'(i) < cc_c) || !younger[i])) begin
        kept_n = kept_n + CNT_W'(1);
      end
    end
    cnt_mid = flush_req ? kept_n : count;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head   <= '0;
      count  <= '0;
      ccount <= '0;
    end else begin
      head   <= head + IDX_W'(drain_fire);
      count  <= cnt_mid - CNT_W'(drain_fire) + CNT_W'(alloc_fire);
      ccount <= cc_c - CNT_W'(drain_fire);
    end
  end

  assign tail = head + IDX_W'(count);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R1
  AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !alloc_fire); // R1
  AST_DRAIN_ONLY_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    drain_fire |-> (ccount != '0)); // R2
  AST_COMMITTED_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
    ccount <= count); // R9
  AST_FLUSH_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (count <= $past(count))); // R9

endmodule

// File: rtl/store_queue_fwd.sv
module store_queue_fwd
  import sqf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int AGE_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       st_alloc_valid,
  output logic                       st_alloc_ready,
  input  logic [AGE_W-1:0]           st_alloc_age,
  output logic [$clog2(DEPTH)-1:0]   st_alloc_slot,
  input  logic                       st_addr_valid,
  input  logic [$clog2(DEPTH)-1:0]   st_addr_slot,
  input  logic [AW-1:0]              st_addr,
  input  logic                       st_data_valid,
  input  logic [$clog2(DEPTH)-1:0]   st_data_slot,
  input  logic [DW-1:0]              st_data,
  input  logic                       st_commit,
  input  logic                       flush_valid,
  input  logic [AGE_W-1:0]           flush_age,
  input  logic                       ld_valid,
  input  logic [AW-1:0]              ld_addr,
  input  logic [AGE_W-1:0]           ld_age,
  output logic                       ld_ready,
  output logic                       ld_fwd_valid,
  output logic [DW-1:0]              ld_fwd_data,
  output logic                       ld_to_cache,
  output logic                       cw_valid,
  input  logic                       cw_ready,
  output logic [AW-1:0]              cw_addr,
  output logic [DW-1:0]              cw_data
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // Physical slot storage
  logic [DEPTH-1:0][AGE_W-1:0] e_age;
  logic [DEPTH-1:0][AW-1:0]    e_addr;
  logic [DEPTH-1:0][DW-1:0]    e_data;
  logic [DEPTH-1:0]            e_av;
  logic [DEPTH-1:0]            e_dv;

  // Views in program order, index 0 = oldest
  logic [DEPTH-1:0][AGE_W-1:0] l_age;
  logic [DEPTH-1:0][AW-1:0]    l_addr;
  logic [DEPTH-1:0][DW-1:0]    l_data;
  logic [DEPTH-1:0]            l_av;
  logic [DEPTH-1:0]            l_dv;
  logic [DEPTH-1:0]            l_live;
  logic [DEPTH-1:0]            older_ld;
  logic [DEPTH-1:0]            younger_fl;

  logic [IDX_W-1:0] head;
  logic [IDX_W-1:0] tail;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] ccount;
  logic             alloc_fire;
  logic             drain_fire;
  ld_verdict_e      verdict;

  assign st_alloc_ready = (count != CNT_W'(DEPTH)) && !flush_valid;
  assign st_alloc_slot  = tail;
  assign alloc_fire     = st_alloc_valid && st_alloc_ready;

  assign cw_valid   = (ccount != '0);
  assign cw_addr    = e_addr[head];
  assign cw_data    = e_data[head];
  assign drain_fire = cw_valid && cw_ready;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_av[s]   <= 1'b0;
        e_dv[s]   <= 1'b0;
        e_age[s]  <= '0;
        e_addr[s] <= '0;
        e_data[s] <= '0;
      end else if (alloc_fire && (tail == IDX_W'(s))) begin
        e_av[s]  <= 1'b0;
        e_dv[s]  <= 1'b0;
        e_age[s] <= st_alloc_age;
      end else begin
        if (st_addr_valid && (st_addr_slot == IDX_W'(s))) begin
          e_av[s]   <= 1'b1;
          e_addr[s] <= st_addr;
        end
        if (st_data_valid && (st_data_slot == IDX_W'(s))) begin
          e_dv[s]   <= 1'b1;
          e_data[s] <= st_data;
        end
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_view
    logic [IDX_W-1:0] ph;
    assign ph        = head + IDX_W'(g);
    assign l_age[g]  = e_age[ph];
    assign l_addr[g] = e_addr[ph];
    assign l_data[g] = e_data[ph];
    assign l_av[g]   = e_av[ph];
    assign l_dv[g]   = e_dv[ph];
    assign l_live[g] = CNT_W'(g) < count;
  end

  sqf_age_cmp #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_age (
    .l_age      (l_age),
    .ld_age     (ld_age),
    .fl_age     (flush_age),
    .older_ld   (older_ld),
    .younger_fl (younger_fl)
  );

  sqf_ld_resolve #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_res (
    .live     (l_live),
    .older    (older_ld),
    .a_known  (l_av),
    .d_known  (l_dv),
    .l_addr   (l_addr),
    .l_data   (l_data),
    .ld_addr  (ld_addr),
    .verdict  (verdict),
    .fwd_data (ld_fwd_data)
  );

  sqf_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .drain_fire (drain_fire),
    .commit_req (st_commit),
    .flush_req  (flush_valid),
    .younger    (younger_fl),
    .head       (head),
    .tail       (tail),
    .count      (count),
    .ccount     (ccount)
  );

  assign ld_ready     = (verdict != LD_STALL);
  assign ld_fwd_valid = ld_valid && (verdict == LD_FWD);
  assign ld_to_cache  = ld_valid && (verdict == LD_BYPASS);

  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ready |-> (!ld_fwd_valid && !ld_to_cache)); // R4
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_fwd_valid, ld_to_cache})); // R6
  AST_CW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && !cw_ready) |=> (cw_valid && $stable(cw_addr) && $stable(cw_data))); // R3
  AST_CW_HEAD_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> (e_av[head] && e_dv[head])); // R2
  AST_FLUSH_BLOCKS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !st_alloc_ready); // R1

endmodule

// File: tb/store_queue_fwd_bench.sv
module store_queue_fwd_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_alloc_valid = 0, st_addr_valid = 0, st_data_valid = 0;
  logic [5:0]  st_alloc_age = 0, flush_age = 0, ld_age = 0;
  logic [2:0]  st_addr_slot = 0, st_data_slot = 0;
  logic [31:0] st_addr = 0, st_data = 0, ld_addr = 0;
  logic        st_commit = 0, flush_valid = 0, ld_valid = 0, cw_ready = 0;
  logic        st_alloc_ready, ld_ready, ld_fwd_valid, ld_to_cache, cw_valid;
  logic [2:0]  st_alloc_slot;
  logic [31:0] ld_fwd_data, cw_addr, cw_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_queue_fwd u_store_queue_fwd (
    .clk(clk), .rst_n(rst_n),
    .st_alloc_valid(st_alloc_valid), .st_alloc_ready(st_alloc_ready),
    .st_alloc_age(st_alloc_age), .st_alloc_slot(st_alloc_slot),
    .st_addr_valid(st_addr_valid), .st_addr_slot(st_addr_slot), .st_addr(st_addr),
    .st_data_valid(st_data_valid), .st_data_slot(st_data_slot), .st_data(st_data),
    .st_commit(st_commit), .flush_valid(flush_valid), .flush_age(flush_age),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_age(ld_age),
    .ld_ready(ld_ready), .ld_fwd_valid(ld_fwd_valid), .ld_fwd_data(ld_fwd_data),
    .ld_to_cache(ld_to_cache), .cw_valid(cw_valid), .cw_ready(cw_ready),
    .cw_addr(cw_addr), .cw_data(cw_data)
  );

  typedef struct {
    int          age;
    logic [31:0] addr;
    bit          av;
    logic [31:0] data;
    bit          dv;
    bit          com;
  } ment_t;

  ment_t mq[$];
  int    mhead = 0;
  int    n_vec = 0, n_bad = 0, cyc = 0;
  string phase = "R10";

  function automatic bit older(int a, int b);
    int d = (b - a) & 63;
    return (d != 0) && (d < 32);
  endfunction

  // expected load outcome: 0 bypass, 1 forward, 2 stall
  function automatic int exp_ld(output logic [31:0] fdat);
    bit unk = 0;
    int hit = -1;
    fdat = '0;
    foreach (mq[k]) begin
      if (older(mq[k].age, int'(ld_age))) begin
        if (!mq[k].av) unk = 1;
        else if (mq[k].addr == ld_addr) hit = k;
      end
    end
    if (unk) return 2;
    if (hit >= 0) begin
      if (!mq[hit].dv) return 2;
      fdat = mq[hit].data;
      return 1;
    end
    return 0;
  endfunction

  function automatic int ncom();
    int n = 0;
    foreach (mq[k]) if (mq[k].com) n++;
    return n;
  endfunction

  task automatic cmp(string tag, string nm, logic [31:0] act, logic [31:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s [%s] %s: actual %h expected %h", tag, phase, nm, act, expv);
    end
  endtask

  task automatic idle();
    st_alloc_valid = 0; st_addr_valid = 0; st_data_valid = 0;
    st_commit = 0; flush_valid = 0; ld_valid = 0; cw_ready = 0;
  endtask

  // One cycle: inputs already set at the falling edge; compare, then update the model.
  task automatic tick();
    logic [31:0] fd;
    int   v;
    bit   e_ar, e_cw;
    #1;
    e_ar = (mq.size() < 8) && !flush_valid;
    e_cw = (mq.size() > 0) && mq[0].com;
    v    = exp_ld(fd);
    cmp("R1", "st_alloc_ready", 32'(st_alloc_ready), 32'(e_ar));
    cmp("R1", "st_alloc_slot", 32'(st_alloc_slot), 32'((mhead + mq.size()) % 8));
    cmp("R2", "cw_valid", 32'(cw_valid), 32'(e_cw));
    if (e_cw) begin
      cmp("R2", "cw_addr", cw_addr, mq[0].addr);
      cmp("R2", "cw_data", cw_data, mq[0].data);
    end
    cmp("R4", "ld_ready", 32'(ld_ready), 32'(v != 2));
    cmp("R6", "ld_fwd_valid", 32'(ld_fwd_valid), 32'(ld_valid && v == 1));
    cmp("R5", "ld_to_cache", 32'(ld_to_cache), 32'(ld_valid && v == 0));
    if (ld_valid && v == 1) cmp("R6", "ld_fwd_data", ld_fwd_data, fd);
    @(posedge clk);
    if (rst_n) begin
      if (st_addr_valid)
        foreach (mq[k]) if ((mhead + k) % 8 == int'(st_addr_slot)) begin
          mq[k].av = 1; mq[k].addr = st_addr;
        end
      if (st_data_valid)
        foreach (mq[k]) if ((mhead + k) % 8 == int'(st_data_slot)) begin
          mq[k].dv = 1; mq[k].data = st_data;
        end
      if (st_commit && ncom() < mq.size()) mq[ncom()].com = 1;
      if (flush_valid)
        while (mq.size() > 0 && !mq[$].com && older(int'(flush_age), mq[$].age))
          void'(mq.pop_back());
      if (e_cw && cw_ready) begin
        void'(mq.pop_front());
        mhead = (mhead + 1) % 8;
      end
      if (st_alloc_valid && e_ar)
        mq.push_back('{age: int'(st_alloc_age), addr: 0, av: 0, data: 0, dv: 0, com: 0});
    end
    @(negedge clk);
  endtask

  task automatic alloc(int age);
    idle(); st_alloc_valid = 1; st_alloc_age = 6'(age); tick(); idle();
  endtask
  task automatic set_addr(int slot, logic [31:0] a);
    idle(); st_addr_valid = 1; st_addr_slot = 3'(slot); st_addr = a; tick(); idle();
  endtask
  task automatic set_data(int slot, logic [31:0] d);
    idle(); st_data_valid = 1; st_data_slot = 3'(slot); st_data = d; tick(); idle();
  endtask
  task automatic load(int age, logic [31:0] a);
    idle(); ld_valid = 1; ld_age = 6'(age); ld_addr = a; tick(); idle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d, actual running expected done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  logic [31:0] pool [4] = '{32'h0000_1000, 32'h0000_2000, 32'h0000_3000, 32'h8000_1000};

  initial begin
    @(negedge clk);
    idle();
    repeat (2) tick();
    rst_n = 1;
    phase = "R10 reset state";
    ld_valid = 1; ld_age = 6'd5; ld_addr = 32'h1234;
    tick(); idle();

    phase = "R1 fill and full";
    for (int k = 0; k < 8; k++) alloc(10 + k);
    alloc(30);

    phase = "R4 unknown older address";
    for (int k = 0; k < 3; k++) set_addr(k, 32'h1000 * (k + 1));
    for (int k = 0; k < 6; k++) set_data(k, 32'hD000_0000 + k);
    load(20, 32'h9000);
    load(13, 32'h9000);

    phase = "R5 bypass, younger match ignored";
    set_addr(3, 32'h4000); set_addr(4, 32'h2000); set_addr(5, 32'h5000);
    set_addr(6, 32'h6000); set_addr(7, 32'h7000);
    load(20, 32'h9000);
    load(12, 32'h5000);

    phase = "R6 youngest older match forwards";
    load(20, 32'h2000);
    load(14, 32'h2000);

    phase = "R7 matching store lacks data";
    load(20, 32'h7000);
    load(17, 32'h6000);

    phase = "R8 full-width compare";
    load(20, 32'h8000_1000);
    set_data(6, 32'hD000_0006); set_data(7, 32'hD000_0007);

    phase = "R3 hold while cache busy";
    for (int k = 0; k < 3; k++) begin idle(); st_commit = 1; tick(); end
    idle(); repeat (3) tick();

    phase = "R2 in-order drain";
    idle(); cw_ready = 1; repeat (4) tick(); idle();

    phase = "R9 flush younger uncommitted";
    idle(); flush_valid = 1; flush_age = 6'd14; st_alloc_valid = 1; st_alloc_age = 6'd40; tick(); idle();
    alloc(15);
    set_addr(5, 32'h3000); set_data(5, 32'h55);
    idle(); st_commit = 1; tick();
    idle(); flush_valid = 1; flush_age = 6'd9; tick(); idle();
    alloc(16);
    idle(); cw_ready = 1; tick(); tick(); idle();

    phase = "mixed traffic";
    begin
      int nage = 17;
      for (int c = 0; c < 3000; c++) begin
        int n = mq.size();
        int nc = ncom();
        idle();
        if ($urandom % 3 != 0) st_alloc_valid = 1;
        st_alloc_age = 6'(nage);
        if (n > 0 && $urandom % 2 == 0) begin
          int k = int'($urandom % n);
          if (!mq[k].av) begin
            st_addr_valid = 1; st_addr_slot = 3'((mhead + k) % 8); st_addr = pool[$urandom % 4];
          end
        end
        if (n > 0 && $urandom % 2 == 0) begin
          int k = int'($urandom % n);
          if (!mq[k].dv) begin
            st_data_valid = 1; st_data_slot = 3'((mhead + k) % 8); st_data = $urandom;
          end
        end
        if (nc < n && mq[nc].av && mq[nc].dv && $urandom % 3 == 0) st_commit = 1;
        if (n > 0 && $urandom % 40 == 0) begin
          flush_valid = 1; flush_age = 6'(mq[$urandom % n].age);
        end
        cw_ready = ($urandom % 2 == 0);
        ld_valid = ($urandom % 4 != 0);
        ld_addr  = pool[$urandom % 4];
        ld_age   = 6'(nage - int'($urandom % 20));
        if (st_alloc_valid && n < 8 && !flush_valid) nage = (nage + 1 + int'($urandom % 2)) & 63;
        tick();
      end
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule